// File: doc/BRIEF.md
# Dual-Mode Power-of-Two Clock Divider

This block derives a slow system clock from a fast reference clock. A fixed halving stage forms a base clock at half the reference rate. A selectable power-of-two division is then applied to that base clock. Two divide exponents are supplied: one for a fast ("high") operating mode and one for a slow ("low") mode. A single mode input chooses between them and may be toggled while the block runs.

The output is not a symmetric square wave. Each output period opens with exactly one reference cycle high, which is the length of one base-clock high phase. The remainder of the period is low, so only the low phase stretches as the division grows. Together with each rising edge the block raises a one-cycle enable. Downstream logic clocked by the reference can use that enable in place of the divided clock.

New settings are taken only when the output falls. That is the boundary between the high phase and the low phase of a period, so no shortened or split pulse can appear.

Control is a small state machine with three states:
- `ST_IDLE` (held in reset). Transition T_START goes to `ST_HIGH` on the first edge after reset is released.
- `ST_HIGH` (output high for one cycle). Transition T_FALL always goes to `ST_LOW` and captures the settings into the low-phase counter.
- `ST_LOW` (output low while the counter runs down). Transition T_HOLD stays in `ST_LOW` while the counter is non-zero. Transition T_RISE goes back to `ST_HIGH` when it reaches zero.

Top module: `cdiv_top`

## Requirements
- R1: After hard reset is released with both exponents 0 and high mode selected, the output has a period of 2 reference cycles. It therefore equals the base clock, the reference divided by two.
- R2: In high mode (`mode_lo` = 0), the output period is 2^(hi_exp+1) reference cycles for hi_exp 0..4.
- R3: In low mode (`mode_lo` = 1), the output period is 2^(lo_exp+2) reference cycles for lo_exp 0..5, so low mode always divides the base clock by at least two.
- R4: Exponents above their legal range saturate. hi_exp 5..7 behaves as 4 (period 32), and lo_exp 6..7 behaves as 5 (period 128).
- R5: In every output period `div_clk` is high for exactly one reference cycle, at the start of the period.
- R6: `div_en` is high in exactly the reference cycles in which `div_clk` is high.
- R7: Mode and exponent inputs are sampled only on the reference edge where `div_clk` falls. A change made during the low phase leaves the current period's length unchanged. A change made while `div_clk` is high already governs the period in progress.
- R8: While `rst_hard` is high, both outputs are 0, including when reset is asserted in the middle of a period. On the first reference edge after release, `div_clk` and `div_en` go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_hard | input | 1 | Asynchronous active-high hard reset |
| hi_exp | input | 3 | High-mode divide exponent (legal 0..4) |
| lo_exp | input | 3 | Low-mode divide exponent (legal 0..5) |
| mode_lo | input | 1 | 0 selects high mode, 1 selects low mode |
| div_clk | output | 1 | Divided clock, registered |
| div_en | output | 1 | One-cycle enable coinciding with each high cycle of div_clk |

## Verification
The key internal failure modes each show up at the ports within one output period.
- A corrupted counter reload or a wrong saturation shows up as the wrong gap between two consecutive rising edges of `div_clk`.
- A stuck or skipped state shows up as a high phase longer than one cycle, or as a missing rise. This is visible within one output period, so at most 128 reference cycles.
- Sampling the inputs at the wrong moment shows up when the mode is switched within a period: the period in progress ends at the new length instead of the old one.
- A faulty reset path shows up as a non-zero output during reset, or as a missing rise on the first edge after release.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } cdiv_state_e;

    function automatic int cdiv_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cdiv_exp_sel.sv
// Clamps both exponent fields and turns the selected one into the
// period exponent measured in reference cycles.
module cdiv_exp_sel #(
    parameter int EXP_W  = 3,
    parameter int HI_MAX = 4,
    parameter int LO_MAX = 5,
    parameter int PE_W   = 3
) (
    input  logic [EXP_W-1:0] hi_exp,
    input  logic [EXP_W-1:0] lo_exp,
    input  logic             mode_lo,
    output logic [PE_W-1:0]  per_exp
);

    logic [EXP_W-1:0] sat [2];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sat
            localparam int CAP = (g == 0) ? HI_MAX : LO_MAX;
            logic [EXP_W-1:0] raw;
            assign raw    = (g == 0) ? hi_exp : lo_exp;
            assign sat[g] = (raw > EXP_W'(CAP)) ? EXP_W'(CAP) : raw;
        end
    endgenerate

    // high mode: base/2^h  -> 2^(h+1) reference cycles
    // low mode : base/2^(l+1) -> 2^(l+2) reference cycles
    always_comb begin
        if (mode_lo) begin
            per_exp = PE_W'(sat[1]) + PE_W'(2);
        end else begin
            per_exp = PE_W'(sat[0]) + PE_W'(1);
        end
    end

endmodule

// File: rtl/cdiv_low_cnt.sv
// Low-phase down counter: loaded with (period - 2) on the falling edge,
// counts to zero through the low phase.
module cdiv_low_cnt #(
    parameter int CNT_W = 7,
    parameter int PE_W  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [PE_W-1:0] per_exp,
    output logic            at_zero
);

    logic [CNT_W-1:0] cnt_q;
    logic [PE_W-1:0]  shamt;
    logic [CNT_W-1:0] reload;

    assign shamt   = PE_W'(CNT_W) - per_exp;
    assign reload  = ({CNT_W{1'b1}} >> shamt) - CNT_W'(1);
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (step && !at_zero) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
    parameter int EXP_W  = 3,
    parameter int HI_MAX = 4,
    parameter int LO_MAX = 5
) (
    input  logic             clk_ref,
    input  logic             rst_hard,
    input  logic [EXP_W-1:0] hi_exp,
    input  logic [EXP_W-1:0] lo_exp,
    input  logic             mode_lo,
    output logic             div_clk,
    output logic             div_en
);
    import cdiv_pkg::*;

    localparam int PER_EXP_MAX = cdiv_max(HI_MAX + 1, LO_MAX + 2);
    localparam int PE_W        = $clog2(PER_EXP_MAX + 1);
    localparam int CNT_W       = PER_EXP_MAX;
    localparam int PER_MAX     = 1 << PER_EXP_MAX;

    cdiv_state_e     st_q;
    cdiv_state_e     st_nxt;
    logic [PE_W-1:0] per_exp;
    logic            cnt_zero;
    logic            div_clk_q;
    logic            div_en_q;

    cdiv_exp_sel #(
        .EXP_W  (EXP_W),
        .HI_MAX (HI_MAX),
        .LO_MAX (LO_MAX),
        .PE_W   (PE_W)
    ) u_sel (
        .hi_exp  (hi_exp),
        .lo_exp  (lo_exp),
        .mode_lo (mode_lo),
        .per_exp (per_exp)
    );

    cdiv_low_cnt #(
        .CNT_W (CNT_W),
        .PE_W  (PE_W)
    ) u_cnt (
        .clk     (clk_ref),
        .rst     (rst_hard),
        .load    (st_q == ST_HIGH),
        .step    (st_q == ST_LOW),
        .per_exp (per_exp),
        .at_zero (cnt_zero)
    );

    // state register
    always_ff @(posedge clk_ref or posedge rst_hard) begin
        if (rst_hard) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // transitions T_START, T_FALL, T_HOLD, T_RISE
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: st_nxt = ST_HIGH;
            ST_HIGH: st_nxt = ST_LOW;
            ST_LOW:  st_nxt = cnt_zero ? ST_HIGH : ST_LOW;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk_ref or posedge rst_hard) begin
        if (rst_hard) begin
            div_clk_q <= 1'b0;
            div_en_q  <= 1'b0;
        end else begin
            div_clk_q <= (st_nxt == ST_HIGH);
            div_en_q  <= (st_nxt == ST_HIGH);
        end
    end

    assign div_clk = div_clk_q;
    assign div_en  = div_en_q;

endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk #(
    parameter int PER_MAX = 128
) (
    input logic clk,
    input logic rst,
    input logic div_clk,
    input logic div_en
);
    localparam int GAP_W = $clog2(PER_MAX) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_clk) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    p_high_one_r5: assert property (@(posedge clk) disable iff (rst)
        div_clk |=> !div_clk);

    p_en_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(div_clk) |-> div_en);

    p_en_single_r6: assert property (@(posedge clk) disable iff (rst)
        div_en |=> !div_en);

    p_period_pow2_r2: assert property (@(posedge clk) disable iff (rst)
        (div_clk && seen_q) |-> ($countones(int'(gap_q) + 1) == 1));

    p_period_cap_r4: assert property (@(posedge clk) disable iff (rst)
        (div_clk && seen_q) |-> ((int'(gap_q) + 1) <= PER_MAX));

    p_reset_quiet_r8: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (!div_clk && !div_en));

    p_first_rise_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(rst, 2) && !$past(rst)) |-> div_clk);

endmodule

bind cdiv_top cdiv_chk #(.PER_MAX(PER_MAX)) u_chk (
    .clk     (clk_ref),
    .rst     (rst_hard),
    .div_clk (div_clk),
    .div_en  (div_en)
);

// File: tb/tb_cdiv_top.sv
module tb_cdiv_top;

    logic       clk_ref = 1'b0;
    logic       rst_hard = 1'b1;
    logic [2:0] hi_exp = 3'd0;
    logic [2:0] lo_exp = 3'd0;
    logic       mode_lo = 1'b0;
    logic       div_clk;
    logic       div_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    cdiv_top dut (
        .clk_ref (clk_ref),
        .rst_hard(rst_hard),
        .hi_exp  (hi_exp),
        .lo_exp  (lo_exp),
        .mode_lo (mode_lo),
        .div_clk (div_clk),
        .div_en  (div_en)
    );

    always #4 clk_ref = ~clk_ref;

    always @(posedge clk_ref) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_per(input bit m, input int h, input int l);
        int e;
        if (m) e = ((l > 5) ? 5 : l) + 2;
        else   e = ((h > 4) ? 4 : h) + 1;
        return 1 << e;
    endfunction

    task automatic wait_rise();
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk_ref);
            if (div_clk) break;
        end
    endtask

    // counts samples from a rise (already counted as start) to the next rise
    task automatic measure(input int start, output int per, output int en_bad);
        per = start;
        en_bad = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk_ref);
            if (div_en != div_clk) en_bad++;
            if (div_clk) break;
            per++;
        end
    endtask

    task automatic t_reset_start();
        repeat (3) @(negedge clk_ref);
        chk(div_clk == 1'b0, "R8 clk in reset", int'(div_clk), 0);
        chk(div_en == 1'b0, "R8 en in reset", int'(div_en), 0);
        rst_hard = 1'b0;
        @(negedge clk_ref);
        chk(div_clk == 1'b1, "R8 first rise", int'(div_clk), 1);
        begin
            int p, e;
            measure(1, p, e);
            chk(p == 2, "R1 base period", p, 2);
            chk(e == 0, "R6 enable match", e, 0);
        end
    endtask

    task automatic t_setting(input bit m, input int h, input int l, input string req);
        int p, e;
        mode_lo = m;
        hi_exp = 3'(h);
        lo_exp = 3'(l);
        wait_rise();
        measure(1, p, e);
        chk(p == exp_per(m, h, l), req, p, exp_per(m, h, l));
        chk(e == 0, "R6 enable match", e, 0);
    endtask

    task automatic t_switch();
        int p, e;
        mode_lo = 1'b1; lo_exp = 3'd3; hi_exp = 3'd1;
        wait_rise();
        measure(1, p, e);
        chk(p == 32, "R3 low exp 3", p, 32);
        // at a rise; move into the low phase, then switch to high mode
        @(negedge clk_ref);
        mode_lo = 1'b0;
        measure(2, p, e);
        chk(p == 32, "R7 change in low phase keeps period", p, 32);
        measure(1, p, e);
        chk(p == 4, "R7 new period after fall", p, 4);
        // at a rise (output high): change now governs this period
        mode_lo = 1'b1; lo_exp = 3'd2;
        measure(1, p, e);
        chk(p == 16, "R7 change while high applies", p, 16);
        chk(e == 0, "R6 enable match", e, 0);
    endtask

    task automatic t_mid_reset();
        int p, e;
        mode_lo = 1'b1; lo_exp = 3'd5;
        wait_rise();
        wait_rise();
        repeat (10) @(negedge clk_ref);
        rst_hard = 1'b1;
        @(negedge clk_ref);
        chk(div_clk == 1'b0 && div_en == 1'b0, "R8 mid-period reset", int'(div_clk), 0);
        repeat (2) @(negedge clk_ref);
        mode_lo = 1'b0; hi_exp = 3'd0; lo_exp = 3'd0;
        rst_hard = 1'b0;
        @(negedge clk_ref);
        chk(div_clk == 1'b1 && div_en == 1'b1, "R8 rise after release", int'(div_clk), 1);
        measure(1, p, e);
        chk(p == 2, "R1 base period after reset", p, 2);
    endtask

    initial begin
        t_reset_start();
        for (int h = 0; h <= 4; h++) t_setting(1'b0, h, 7, "R2 high mode period");
        for (int l = 0; l <= 5; l++) t_setting(1'b1, 7, l, "R3 low mode period");
        for (int h = 5; h <= 7; h++) t_setting(1'b0, h, 0, "R4 high saturation");
        for (int l = 6; l <= 7; l++) t_setting(1'b1, 0, l, "R4 low saturation");
        t_switch();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule